// File: doc/BRIEF.md
# Calibrated PWM Channel Gate Controller

This block produces the on/off command for each of two power-switch channels. A channel's command can follow a direct input pin, or a pulse-width modulator that compares an 8-bit phase counter against an 8-bit duty value. The phase counter advances once per internal tick, so one full switching period lasts 256 ticks. Each channel has its own tick divider, which holds the number of system clock cycles per tick.

The tick length starts at a fixed default. It can be recalibrated from outside through a short procedure. Register logic pulses an arm strobe for one or both channels. The block then times the next low pulse on the serial chip-select line. If the pulse width falls inside an accepted window, the width divided by a fixed power-of-two scale becomes the new tick length for the armed channels. A pulse outside the window leaves every tick length unchanged. Each channel also emits a one-cycle strobe when its modulated output turns off, which downstream logic can use for synchronisation.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While reset is held low, with all control inputs at 0, every command output and every sync strobe output is 0.
- R2: A channel's command is 1 whenever its direct input and its direct-disable bit are both 1, whatever the other control bits are.
- R3: With the on bit set and PWM disabled, the command is 1. With the on bit clear and the direct term inactive, the command is 0.
- R4: With the on bit set and PWM enabled, the command is 1 exactly while the phase counter is below the duty value. The phase counter is 0 in the cycle PWM is enabled and advances by one per tick, modulo 256. A duty of 0 keeps the command off, and a duty of 255 keeps it on for 255 of every 256 ticks.
- R5: After reset, each channel's tick lasts DEF_TICKS clock cycles (default 2) until a calibration is accepted.
- R6: A calibration pulse that is sampled low on L consecutive clock edges, with CAL_MIN <= L <= CAL_MAX (default 8 to 40), sets the tick length of the armed channels to floor(L / 2^CAL_SHIFT) (default scale 4). Channels that were not armed keep their tick length.
- R7: A calibration pulse with L below CAL_MIN or above CAL_MAX is discarded, and every tick length stays unchanged.
- R8: A chip-select low pulse with no preceding arm strobe changes no tick length. Only the first falling edge after the arm strobe is measured. Bit i of the arm vector selects channel i.
- R9: The sync strobe of a channel is high for exactly one cycle in each cycle where its PWM output has just gone from high to low while PWM stays enabled. It never pulses when the duty is 0.
- R10: Two channels with equal tick lengths that are enabled in the same cycle keep their phase counters equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | N_CH | Direct input pin per channel |
| dir_dis | input | N_CH | Direct-disable bit per channel; 1 lets the direct input drive the command |
| on_bit | input | N_CH | Register on bit per channel |
| pwm_en | input | N_CH | PWM enable per channel; 0 holds the time base at phase 0 |
| duty | input | N_CH*DUTY_W | Duty value per channel; channel i occupies bits [i*DUTY_W +: DUTY_W] |
| cal_arm | input | N_CH | One-cycle arm strobe per channel for the calibration procedure |
| cs_n | input | 1 | Serial chip-select line, active low, synchronous to clk |
| cmd | output | N_CH | Target on/off command per channel |
| sync_strb | output | N_CH | One-cycle strobe at each PWM turn-off edge |

## Verification
The bench sweeps duty values from 0 to 255 over complete 256-tick periods on both channels at once. A design that counts the phase one tick off, or compares with less-or-equal, would show a command that is wrong at one phase boundary. Such a design would also either pulse the sync strobe at duty 0 or miss it at duty 255. Calibration pulses are driven at the window limits (7, 8, 40 and 41 cycles) and also without an arm strobe. An off-by-one window compare, a missing divide, or a tick change applied to an unarmed channel each show up as a shifted phase-0 interval in the PWM trace that follows. All 32 combinations of the command-rule inputs are applied to catch a wrong term in the merge.

// File: rtl/pwm_gate_pkg.sv
// Shared types for the calibrated PWM channel gate controller.
package pwm_gate_pkg;

    // States of the chip-select pulse measurement.
    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_WAIT = 2'd1,
        CAL_MEAS = 2'd2
    } cal_state_e;

endpackage

// File: rtl/pwm_gate_cal.sv
// Calibration unit: after an arm strobe, times the next low pulse on cs_n
// in clock cycles. A width inside [CAL_MIN, CAL_MAX] produces a one-cycle
// load pulse that carries width >> CAL_SHIFT and the armed channel mask.
// Assumes cs_n is already synchronous to clk. Arm strobes are taken only
// while idle.
module pwm_gate_cal
    import pwm_gate_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int TICK_W    = 16,
    parameter int CAL_SHIFT = 2,
    parameter int CAL_MIN   = 8,
    parameter int CAL_MAX   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   cal_arm,
    input  logic              cs_n,
    output logic              cal_load,
    output logic [N_CH-1:0]   cal_mask,
    output logic [TICK_W-1:0] cal_ticks
);

    localparam int MEAS_W = $clog2(CAL_MAX + 2);
    localparam logic [MEAS_W-1:0] MIN_W = MEAS_W'(CAL_MIN);
    localparam logic [MEAS_W-1:0] MAX_W = MEAS_W'(CAL_MAX);

    cal_state_e        state_q;
    logic              cs_q;
    logic              cs_fall;
    logic [MEAS_W-1:0] width_q;
    logic [N_CH-1:0]   mask_q;
    logic              load_q;
    logic [TICK_W-1:0] ticks_q;

    // Falling edge of chip-select relative to the previous sample.
    assign cs_fall = cs_q & ~cs_n;

    // Arm, wait for the falling edge, count low cycles, judge on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            cs_q    <= 1'b1;
            width_q <= '0;
            mask_q  <= '0;
            load_q  <= 1'b0;
            ticks_q <= '0;
        end else begin
            cs_q   <= cs_n;
            load_q <= 1'b0;
            case (state_q)
                CAL_IDLE: begin
                    if (|cal_arm) begin
                        mask_q  <= cal_arm;
                        state_q <= CAL_WAIT;
                    end
                end
                CAL_WAIT: begin
                    if (cs_fall) begin
                        width_q <= MEAS_W'(1);
                        state_q <= CAL_MEAS;
                    end
                end
                CAL_MEAS: begin
                    if (cs_n) begin
                        state_q <= CAL_IDLE;
                        if (width_q >= MIN_W && width_q <= MAX_W) begin
                            load_q  <= 1'b1;
                            ticks_q <= TICK_W'(width_q >> CAL_SHIFT);
                        end
                    end else if (width_q <= MAX_W) begin
                        width_q <= width_q + MEAS_W'(1);
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    assign cal_load  = load_q;
    assign cal_mask  = mask_q;
    assign cal_ticks = ticks_q;

    // R6
    cal_ticks_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |-> (cal_ticks != '0));

    // R8
    cal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_load |-> ($past(state_q) == CAL_MEAS && cal_mask != '0));

    // R7
    width_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_MEAS && $past(state_q) == CAL_MEAS) |-> (width_q >= $past(width_q)));

endmodule

// File: rtl/pwm_gate_chan.sv
// One channel: tick divider, 8-bit phase counter, duty compare, turn-off
// strobe and the command merge rule. The time base is held at zero while
// PWM is disabled, so channels enabled in the same cycle start aligned.
// Assumes the tick length loaded from calibration is nonzero.
module pwm_gate_chan #(
    parameter int DUTY_W    = 8,
    parameter int TICK_W    = 16,
    parameter int DEF_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              dir_dis,
    input  logic              on_bit,
    input  logic              pwm_en,
    input  logic [DUTY_W-1:0] duty,
    input  logic              tick_load,
    input  logic [TICK_W-1:0] tick_val,
    output logic              cmd,
    output logic              sync_strb
);

    logic [TICK_W-1:0] per_q;
    logic [TICK_W-1:0] presc_q;
    logic [DUTY_W-1:0] phase_q;
    logic              pwm_hi;
    logic              hi_q;

    // Tick length register: default at reset, replaced by accepted calibration.
    always_ff @(posedge clk) begin
        if (!rst_n) per_q <= TICK_W'(DEF_TICKS);
        else if (tick_load) per_q <= tick_val;
    end

    // Tick divider and phase counter, cleared while PWM is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwm_en) begin
            presc_q <= '0;
            phase_q <= '0;
        end else if (presc_q >= per_q - TICK_W'(1)) begin
            presc_q <= '0;
            phase_q <= phase_q + DUTY_W'(1);
        end else begin
            presc_q <= presc_q + TICK_W'(1);
        end
    end

    assign pwm_hi = pwm_en && (phase_q < duty);

    // Previous PWM level for turn-off edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= pwm_hi;
    end

    assign sync_strb = pwm_en & hi_q & ~pwm_hi;
    assign cmd = (din & dir_dis) | (on_bit & pwm_hi) | (on_bit & ~pwm_en);

    // R9
    sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_strb |=> !sync_strb);

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && $past(pwm_en)) |->
            (phase_q == $past(phase_q) || phase_q == DUTY_W'($past(phase_q) + 1'b1)));

    // R5
    period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_q != '0);

    // R3
    on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_bit && !pwm_en) |-> cmd);

endmodule

// File: rtl/pwm_gate_ctrl.sv
// Top: a shared calibration unit feeding N_CH PWM channels. An accepted
// calibration loads the measured tick length into every channel whose
// arm bit was set. Assumes cs_n is synchronous to clk.
module pwm_gate_ctrl #(
    parameter int N_CH      = 2,
    parameter int DUTY_W    = 8,
    parameter int TICK_W    = 16,
    parameter int DEF_TICKS = 2,
    parameter int CAL_SHIFT = 2,
    parameter int CAL_MIN   = 8,
    parameter int CAL_MAX   = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH-1:0]          din,
    input  logic [N_CH-1:0]          dir_dis,
    input  logic [N_CH-1:0]          on_bit,
    input  logic [N_CH-1:0]          pwm_en,
    input  logic [N_CH*DUTY_W-1:0]   duty,
    input  logic [N_CH-1:0]          cal_arm,
    input  logic                     cs_n,
    output logic [N_CH-1:0]          cmd,
    output logic [N_CH-1:0]          sync_strb
);

    logic              cal_load;
    logic [N_CH-1:0]   cal_mask;
    logic [TICK_W-1:0] cal_ticks;

    pwm_gate_cal #(
        .N_CH(N_CH), .TICK_W(TICK_W), .CAL_SHIFT(CAL_SHIFT),
        .CAL_MIN(CAL_MIN), .CAL_MAX(CAL_MAX)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .cal_arm(cal_arm), .cs_n(cs_n),
        .cal_load(cal_load), .cal_mask(cal_mask), .cal_ticks(cal_ticks)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        pwm_gate_chan #(
            .DUTY_W(DUTY_W), .TICK_W(TICK_W), .DEF_TICKS(DEF_TICKS)
        ) u_chan (
            .clk(clk), .rst_n(rst_n),
            .din(din[i]), .dir_dis(dir_dis[i]), .on_bit(on_bit[i]),
            .pwm_en(pwm_en[i]), .duty(duty[i*DUTY_W +: DUTY_W]),
            .tick_load(cal_load & cal_mask[i]), .tick_val(cal_ticks),
            .cmd(cmd[i]), .sync_strb(sync_strb[i])
        );
    end

    // R9
    sync_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_strb & ~pwm_en) == '0);

endmodule

// File: tb/pwm_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_gate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] din, dir_dis, on_bit, pwm_en, cal_arm;
    logic [15:0] duty;
    logic       cs_n;
    logic [1:0] cmd, sync_strb;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .dir_dis(dir_dis),
        .on_bit(on_bit), .pwm_en(pwm_en), .duty(duty), .cal_arm(cal_arm),
        .cs_n(cs_n), .cmd(cmd), .sync_strb(sync_strb)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d actual=%0b expected=%0b", req, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Run both channels from phase 0 and compare each cycle to the phase formula.
    task automatic run_pwm(int d0, int d1, int p0, int p1, int ncyc, string req);
        logic prev0 = 1'b0, prev1 = 1'b0;
        duty   = {8'(d1), 8'(d0)};
        on_bit = 2'b11; dir_dis = 2'b00; din = 2'b00;
        pwm_en = 2'b11;
        #1;
        for (int n = 0; n <= ncyc; n++) begin
            logic e0, e1;
            if (n > 0) step();
            e0 = ((n / p0) % 256) < d0;
            e1 = ((n / p1) % 256) < d1;
            chk(req, cmd[0], e0);
            chk(req, cmd[1], e1);
            chk(req, sync_strb[0], prev0 & ~e0);
            chk(req, sync_strb[1], prev1 & ~e1);
            prev0 = e0; prev1 = e1;
        end
        pwm_en = 2'b00;
        step();
    endtask

    task automatic do_cal(logic [1:0] mask, int len);
        cal_arm = mask;
        step();
        cal_arm = 2'b00;
        step();
        cs_n = 1'b0;
        repeat (len) step();
        cs_n = 1'b1;
        repeat (3) step();
    endtask

    initial begin
        rst_n = 1'b0; din = '0; dir_dis = '0; on_bit = '0; pwm_en = '0;
        duty = '0; cal_arm = '0; cs_n = 1'b1;
        repeat (3) begin
            step();
            chk("R1", cmd[0], 1'b0); chk("R1", cmd[1], 1'b0);
            chk("R1", sync_strb[0], 1'b0); chk("R1", sync_strb[1], 1'b0);
        end
        rst_n = 1'b1;
        step();

        // R2 R3: all merge-rule input combinations, PWM at phase 0.
        for (int v = 0; v < 32; v++) begin
            logic [4:0] b = 5'(v);
            logic e;
            din = {2{b[0]}}; dir_dis = {2{b[1]}}; on_bit = {2{b[2]}};
            pwm_en = {2{b[3]}}; duty = b[4] ? 16'hFFFF : 16'h0000;
            #1;
            e = (b[0] & b[1]) | (b[2] & b[3] & b[4]) | (b[2] & ~b[3]);
            chk("R2 R3", cmd[0], e);
            chk("R2 R3", cmd[1], e);
            pwm_en = 2'b00;
            step();
        end

        // R4 R5 R9 R10: duty sweep over full periods, default tick length.
        for (int d = 0; d <= 255; d += 17)
            run_pwm(d, 255 - d, 2, 2, 2 * 256 + 4, "R4 R5 R9 R10");

        do_cal(2'b01, 20);                // width 20 -> 5 ticks on ch0 only
        run_pwm(1, 1, 5, 2, 17, "R6 R8");
        do_cal(2'b11, 7);                 // below window
        run_pwm(1, 1, 5, 2, 17, "R7");
        do_cal(2'b11, 41);                // above window
        run_pwm(1, 1, 5, 2, 17, "R7");
        cs_n = 1'b0; repeat (20) step(); cs_n = 1'b1; repeat (3) step();
        run_pwm(1, 1, 5, 2, 17, "R8");    // unarmed pulse
        do_cal(2'b10, 12);                // 3 ticks on ch1 only
        run_pwm(1, 1, 5, 3, 17, "R6 R8");
        do_cal(2'b11, 8);                 // lower limit -> 2 on both
        run_pwm(1, 2, 2, 2, 8, "R6");
        do_cal(2'b01, 40);                // upper limit -> 10 on ch0
        run_pwm(2, 1, 10, 2, 32, "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule